// File: doc/BRIEF.md
# Mains-Locked Tick Multiplier (All-Digital Loop)

This block derives a fast tick train from a slow, already-squared mains reference by closing an all-digital loop around a programmable-period oscillator. A counter-based oscillator emits one system-clock-wide tick every `modulus` cycles. A divide-by-N stage turns the ticks into a square feedback wave, and a JK-style phase detector compares that wave with the synchronized reference. The detector drives an up/down integrating counter. When that counter overflows, the oscillator period grows by one cycle. When it underflows, the period shrinks by one cycle.

The loop never adds or removes output ticks to pull into step. It corrects only by retuning the period, so every feedback period holds exactly N ticks. When the loop follows the reference, every reference period therefore holds N ticks as well. With the defaults (30 MHz system clock, nominal period 15000, divide-by-40) a 50 Hz reference gives a 2 kHz tick. The period may move between 14850 and 15150 cycles, which covers about ±1 % of reference deviation. A lock flag reports when the period has stayed put for a run of reference periods.

Top module: `mains_adpll`

## Requirements
- R1: While `rst` is high, `tickOut` and `lockOut` are 0 and `fbOut` is 1. The oscillator period restarts at `MOD_NOM`.
- R2: Consecutive `tickOut` pulses are exactly `modulus` cycles apart, each pulse is one cycle wide, and `modulus` starts at `MOD_NOM`.
- R3: `fbOut` rises on the same cycle as a tick and stays high for the first `FB_DIV/2` ticks of each feedback period. Every feedback period contains exactly `FB_DIV` ticks.
- R4: The phase detector is set by a feedback rising edge and cleared by a rising edge of the reference after it passes through `SYNC_STAGES` flops and edge detection. When both edges arrive in the same cycle, the detector toggles.
- R5: The integrating counter counts up while the detector is set and down while it is clear, over the range 0 to `K_MODULUS-1`. When it passes the top, the modulus steps up by 1; when it passes 0, the modulus steps down by 1. After either event the counter reloads `K_MODULUS/2`, and the modulus moves by at most 1 per cycle.
- R6: The modulus is clamped to `MOD_MIN`..`MOD_MAX`. Without a reference it settles at `MOD_MAX`. With a reference far faster than the feedback it settles at `MOD_MIN`. With a reference far slower than the feedback it settles at `MOD_MAX`.
- R7: `lockOut` goes to 1 after `LOCK_PERIODS` consecutive reference periods in which up-steps equal down-steps and the modulus lies strictly inside the clamp range. A reference that matches the feedback frequency leaves the modulus at `MOD_NOM` and gives lock.
- R8: A reference edge that closes a period with a net step, or that finds the modulus at either clamp, clears `lockOut` on the next cycle. While the loop is railed, `lockOut` stays 0.
- R9: The loop never inserts or deletes ticks. While it follows the reference, each reference period contains exactly `FB_DIV` ticks.
- R10: Asserting `rst` while locked drops `lockOut` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| refIn | input | 1 | Squared mains reference, asynchronous to `clk` |
| tickOut | output | 1 | One-cycle tick at the multiplied rate |
| fbOut | output | 1 | Feedback square wave, ticks divided by `FB_DIV` |
| lockOut | output | 1 | Loop frequency-lock flag |

## Verification
The embedded properties take the reference to be a clean two-level signal with no sub-cycle glitches. They also take its period to be far longer than the synchronizer depth, and `MOD_MIN` to be at least 2 so that ticks can never merge. The stimulus changes the reference only on falling clock edges, so the synchronizer sees stable levels. The reference is either held low, run as a square wave whose half period is an integer number of clocks, or taken as the inverse of the feedback output, which gives a frequency match with a half-period phase offset. The bench uses a small nominal modulus and an integrating range of four feedback periods. This keeps the matched case free of counter overflow for the whole run, while the railed cases reach their clamp well within the settle time.

// File: rtl/mains_adpll_pkg.sv
package mains_adpll_pkg;

  // Period retune strobes passed from control to datapath.
  typedef struct packed {
    logic incMod;
    logic decMod;
  } modStepT;

endpackage

// File: rtl/mains_adpll_dp.sv
module mains_adpll_dp
  import mains_adpll_pkg::*;
#(
  parameter int MOD_NOM = 15000,
  parameter int MOD_MIN = 14850,
  parameter int MOD_MAX = 15150,
  parameter int FB_DIV  = 40
) (
  input  logic    clk,
  input  logic    rst,
  input  modStepT step,
  output logic    tickQ,
  output logic    fbRiseQ,
  output logic    fbLevel,
  output logic    atBound
);

  localparam int MOD_W = $clog2(MOD_MAX + 1);
  localparam int DIV_W = (FB_DIV > 2) ? $clog2(FB_DIV) : 1;
  localparam int HALF  = FB_DIV / 2;

  logic [MOD_W-1:0] modReg;
  logic [MOD_W-1:0] dcoCnt;
  logic [DIV_W-1:0] divCnt;
  logic             dcoWrap;
  logic             divWrap;

  // Modulus register with clamping at both ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      modReg <= MOD_W'(MOD_NOM);
    end else if (step.incMod && !step.decMod) begin
      if (modReg < MOD_W'(MOD_MAX)) modReg <= modReg + MOD_W'(1);
    end else if (step.decMod && !step.incMod) begin
      if (modReg > MOD_W'(MOD_MIN)) modReg <= modReg - MOD_W'(1);
    end
  end

  assign atBound = (modReg == MOD_W'(MOD_MIN)) || (modReg == MOD_W'(MOD_MAX));

  // Oscillator: a modulus counter that wraps once every modReg cycles.
  assign dcoWrap = (dcoCnt >= modReg - MOD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dcoCnt <= '0;
      tickQ  <= 1'b0;
    end else begin
      dcoCnt <= dcoWrap ? '0 : dcoCnt + MOD_W'(1);
      tickQ  <= dcoWrap;
    end
  end

  // Feedback divider, advanced once per tick.
  assign divWrap = (divCnt == DIV_W'(FB_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      fbRiseQ <= 1'b0;
    end else begin
      fbRiseQ <= dcoWrap && divWrap;
      if (dcoWrap) divCnt <= divWrap ? '0 : divCnt + DIV_W'(1);
    end
  end

  assign fbLevel = (divCnt < DIV_W'(HALF));

  AST_MOD_RANGE: assert property (@(posedge clk) disable iff (rst)
    (modReg >= MOD_W'(MOD_MIN)) && (modReg <= MOD_W'(MOD_MAX))); // R6
  AST_MOD_STEP: assert property (@(posedge clk) disable iff (rst)
    ((modReg - $past(modReg)) <= MOD_W'(1)) || (($past(modReg) - modReg) <= MOD_W'(1))); // R5
  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    tickQ |=> !tickQ); // R2
  AST_FB_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    fbRiseQ |-> (tickQ && fbLevel)); // R3
  AST_FB_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(divCnt) |-> tickQ); // R3

endmodule

// File: rtl/mains_adpll_ctrl.sv
module mains_adpll_ctrl
  import mains_adpll_pkg::*;
#(
  parameter int K_MODULUS    = 300000,
  parameter int LOCK_PERIODS = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    refIn,
  input  logic    fbRise,
  input  logic    atBound,
  output modStepT step,
  output logic    lockQ
);

  localparam int K_W    = $clog2(K_MODULUS);
  localparam int K_MID  = K_MODULUS / 2;
  localparam int LOCK_W = $clog2(LOCK_PERIODS + 1);
  localparam int NET_W  = 4;
  localparam int NET_LIM = (1 << (NET_W - 1)) - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   refDly;
  logic                   refEdge;
  logic                   pdQ;
  logic [K_W-1:0]         kCnt;
  logic                   carry;
  logic                   borrow;
  logic signed [NET_W-1:0] netSteps;
  logic signed [NET_W-1:0] netNext;
  logic [LOCK_W-1:0]      lockCnt;
  logic [LOCK_W-1:0]      lockCntNext;

  // Reference synchronizer, one flop per stage.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) syncChain[0] <= 1'b0;
          else     syncChain[0] <= refIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (rst) syncChain[s] <= 1'b0;
          else     syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) refDly <= 1'b0;
    else     refDly <= syncChain[SYNC_STAGES-1];
  end

  assign refEdge = syncChain[SYNC_STAGES-1] && !refDly;

  // JK phase detector: feedback sets, reference clears, both toggle.
  always_ff @(posedge clk) begin
    if (rst) begin
      pdQ <= 1'b0;
    end else begin
      unique case ({fbRise, refEdge})
        2'b10:   pdQ <= 1'b1;
        2'b01:   pdQ <= 1'b0;
        2'b11:   pdQ <= !pdQ;
        default: pdQ <= pdQ;
      endcase
    end
  end

  // Integrating up/down counter with overflow and underflow strobes.
  assign carry  = pdQ && (kCnt == K_W'(K_MODULUS - 1));
  assign borrow = !pdQ && (kCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      kCnt <= K_W'(K_MID);
    end else if (carry || borrow) begin
      kCnt <= K_W'(K_MID);
    end else if (pdQ) begin
      kCnt <= kCnt + K_W'(1);
    end else begin
      kCnt <= kCnt - K_W'(1);
    end
  end

  assign step.incMod = carry;
  assign step.decMod = borrow;

  // Net step tally over one reference period, saturating.
  always_comb begin
    netNext = netSteps;
    if (carry && netSteps < NET_W'(NET_LIM))   netNext = netSteps + NET_W'(1);
    if (borrow && netSteps > -NET_W'(NET_LIM)) netNext = netSteps - NET_W'(1);
  end

  always_comb begin
    lockCntNext = lockCnt;
    if (refEdge) begin
      if ((netSteps == '0) && !atBound) begin
        if (lockCnt < LOCK_W'(LOCK_PERIODS)) lockCntNext = lockCnt + LOCK_W'(1);
      end else begin
        lockCntNext = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      netSteps <= '0;
      lockCnt  <= '0;
      lockQ    <= 1'b0;
    end else begin
      netSteps <= refEdge ? (netNext - netSteps) : netNext;
      lockCnt  <= lockCntNext;
      lockQ    <= (lockCntNext >= LOCK_W'(LOCK_PERIODS));
    end
  end

  AST_KCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    kCnt <= K_W'(K_MODULUS - 1)); // R5
  AST_STEP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(step.incMod && step.decMod)); // R5
  AST_STEP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (carry || borrow) |=> (kCnt == K_W'(K_MID))); // R5
  AST_PD_SET: assert property (@(posedge clk) disable iff (rst)
    (fbRise && !refEdge) |=> pdQ); // R4
  AST_PD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (refEdge && !fbRise) |=> !pdQ); // R4
  AST_LOCK_AT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (refEdge && atBound) |=> !lockQ); // R8
  AST_LOCK_NET: assert property (@(posedge clk) disable iff (rst)
    (refEdge && (netSteps != '0)) |=> !lockQ); // R8
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !refEdge |=> $stable(lockQ)); // R7

endmodule

// File: rtl/mains_adpll.sv
module mains_adpll
  import mains_adpll_pkg::*;
#(
  parameter int MOD_NOM      = 15000,
  parameter int MOD_MIN      = 14850,
  parameter int MOD_MAX      = 15150,
  parameter int FB_DIV       = 40,
  parameter int K_MODULUS    = 300000,
  parameter int LOCK_PERIODS = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic refIn,
  output logic tickOut,
  output logic fbOut,
  output logic lockOut
);

  modStepT stepBus;
  logic    fbRise;
  logic    atBound;

  mains_adpll_ctrl #(
    .K_MODULUS   (K_MODULUS),
    .LOCK_PERIODS(LOCK_PERIODS),
    .SYNC_STAGES (SYNC_STAGES)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .refIn  (refIn),
    .fbRise (fbRise),
    .atBound(atBound),
    .step   (stepBus),
    .lockQ  (lockOut)
  );

  mains_adpll_dp #(
    .MOD_NOM(MOD_NOM),
    .MOD_MIN(MOD_MIN),
    .MOD_MAX(MOD_MAX),
    .FB_DIV (FB_DIV)
  ) uDp (
    .clk    (clk),
    .rst    (rst),
    .step   (stepBus),
    .tickQ  (tickOut),
    .fbRiseQ(fbRise),
    .fbLevel(fbOut),
    .atBound(atBound)
  );

  AST_RST_OUTS: assert property (@(posedge clk)
    $past(rst) |-> (!tickOut && !lockOut && fbOut)); // R1

endmodule

// File: tb/tb_mains_adpll.sv
module tb_mains_adpll;

  localparam int NOM   = 100;
  localparam int MINM  = 97;
  localparam int MAXM  = 103;
  localparam int DIV   = 8;
  localparam int PER   = NOM * DIV;
  localparam int KMOD  = 4 * PER;
  localparam int LOCKN = 8;
  localparam int SETTLE = 30000;

  // Scenario vector: {mode[1:0], genHalf[15:0], expInterval[7:0], expLock}
  // mode 0 = reference held low, 1 = inverse of fbOut, 2 = generated square
  localparam int NVEC = 4;
  localparam logic [26:0] VEC [NVEC] = '{
    {2'd0, 16'd0,    8'(MAXM), 1'b0},  // no reference
    {2'd2, 16'd100,  8'(MINM), 1'b0},  // fast reference
    {2'd2, 16'd4000, 8'(MAXM), 1'b0},  // slow reference
    {2'd1, 16'd0,    8'(NOM),  1'b1}   // matched reference
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refGen = 1'b0;
  logic followMode = 1'b0;
  int   genHalf = 0;
  logic refIn;
  logic tickOut, fbOut, lockOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign refIn = followMode ? ~fbOut : refGen;

  mains_adpll #(
    .MOD_NOM(NOM), .MOD_MIN(MINM), .MOD_MAX(MAXM), .FB_DIV(DIV),
    .K_MODULUS(KMOD), .LOCK_PERIODS(LOCKN), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst(rst), .refIn(refIn),
    .tickOut(tickOut), .fbOut(fbOut), .lockOut(lockOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference generator: toggles only on falling edges.
  initial begin
    forever begin
      if (genHalf != 0) begin
        repeat (genHalf) @(negedge clk);
        refGen = ~refGen;
      end else begin
        refGen = 1'b0;
        @(negedge clk);
      end
    end
  end

  task automatic waitRise(input bit useRef);
    logic prev;
    prev = useRef ? refIn : fbOut;
    forever begin
      @(negedge clk);
      if ((useRef ? refIn : fbOut) && !prev) break;
      prev = useRef ? refIn : fbOut;
    end
  endtask

  // Counts ticks in (rise, next rise] and the last tick spacing.
  task automatic measure(input bit useRef, output int ticks, output int spacing);
    logic prev;
    int since;
    ticks = 0; spacing = 0; since = 0;
    waitRise(useRef);
    prev = useRef ? refIn : fbOut;
    forever begin
      @(negedge clk);
      since++;
      if (tickOut) begin
        ticks++;
        spacing = since;
        since = 0;
      end
      if ((useRef ? refIn : fbOut) && !prev) break;
      prev = useRef ? refIn : fbOut;
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int ticks, spacing;
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    check(tickOut == 1'b0, "R1 tick in reset", int'(tickOut), 0);
    check(lockOut == 1'b0, "R1 lock in reset", int'(lockOut), 0);
    check(fbOut == 1'b1,   "R1 fb in reset",   int'(fbOut), 1);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] mode;
      int expInt;
      logic expLock;
      mode    = VEC[v][26:25];
      expInt  = int'(VEC[v][8:1]);
      expLock = VEC[v][0];
      rst = 1'b1;
      followMode = (mode == 2'd1);
      genHalf = int'(VEC[v][24:9]);
      doReset();
      repeat (SETTLE) @(negedge clk);
      measure(1'b0, ticks, spacing);
      // R2/R5/R6: tick spacing equals settled modulus (rail or nominal)
      check(spacing == expInt, $sformatf("R6 R2 interval vec%0d", v), spacing, expInt);
      // R3: ticks per feedback period
      check(ticks == DIV, $sformatf("R3 ticks per fb vec%0d", v), ticks, DIV);
      // R7/R8: lock state
      check(lockOut == expLock, $sformatf("R7 R8 lock vec%0d", v), int'(lockOut), int'(expLock));
      if (mode == 2'd1) begin
        // R9: ticks per reference period when following
        measure(1'b1, ticks, spacing);
        check(ticks == DIV, "R9 ticks per reference period", ticks, DIV);
        check(spacing == NOM, "R4 matched phase keeps modulus", spacing, NOM);
        // R10: reset drops lock on next edge
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(lockOut == 1'b0, "R10 lock after reset", int'(lockOut), 0);
        check(tickOut == 1'b0, "R1 tick after reset", int'(tickOut), 0);
        rst = 1'b0;
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule